// File: doc/BRIEF.md
# Two-Level Page Translation Unit

The unit turns 32-bit linear addresses into physical addresses. A request is taken through a ready/valid handshake. The unit first tries a 32-entry fully associative translation cache. On a miss it walks a two-level table in memory through a single-beat read port. It first reads a directory entry. A directory entry can map a 4 MB page directly, which ends the walk there; otherwise it points to a page table, and a second read fetches the entry for the 4 KB page. Each result comes back as a one-cycle pulse that carries either the physical address or a fault flag.

The directory lives at a page-aligned base that software loads through a write strobe. Loading the base empties the cache, and so does a flush pulse. Refills replace cache entries in round-robin order. A clear present bit at either table level ends the walk with a fault and leaves the cache unchanged.

Control is one state machine in the walker, with these states and transitions:
- `S_IDLE` goes to `S_PROBE` when a request is accepted.
- `S_PROBE` goes to `S_DONE` on a cache hit and to `S_DIR_REQ` on a miss.
- `S_DIR_REQ` always goes to `S_DIR_WAIT`.
- `S_DIR_WAIT` waits for read data. It goes to `S_DONE` on a fault or on a 4 MB entry, and to `S_PT_REQ` otherwise.
- `S_PT_REQ` always goes to `S_PT_WAIT`.
- `S_PT_WAIT` goes to `S_DONE` once read data arrives.
- `S_DONE` always goes back to `S_IDLE`.

Top module: `pgx_xlate_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and the cache holds no valid entry.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the result has been delivered. `rsp_valid` is high for exactly one cycle per request and falls in the cycle after it rises.
- R3: On a cache hit, `rsp_valid` rises one clock edge after the accepting edge. The result is the cached frame joined with the offset bits of the linear address.
- R4: A miss starts with one single-cycle read request at address `{dir_base[19:0], lin[31:22], 2'b00}`. The walker then waits for `mem_rsp_valid`, whatever the number of cycles.
- R5: A directory entry with bit 0 (present) and bit 7 (large page) both set ends the walk. The result is `{pde[31:22], lin[21:0]}`, the page is entered into the cache as a 4 MB page, and with a one-cycle memory the result comes 3 edges after acceptance.
- R6: A present directory entry with bit 7 clear leads to a second read at `{pde[31:12], lin[21:12], 2'b00}`. A present table entry gives `{pte[31:12], lin[11:0]}` and fills a 4 KB page. With a one-cycle memory this takes 5 edges.
- R7: A clear bit 0 in either entry gives `rsp_fault`=1 and `rsp_phys`=0, and nothing is written to the cache. Repeating the same address walks again.
- R8: A 4 MB cache entry matches on `lin[31:22]` only. A 4 KB entry matches on `lin[31:12]`.
- R9: Refills go to the 32 slots in round-robin order. The 33rd refill replaces the entry written 32 refills earlier.
- R10: A one-cycle `flush` pulse invalidates every entry in the cycle after the pulse.
- R11: `dir_base_wr` loads `dir_base_in` as the directory base, which later walks use, and it invalidates all entries as a flush does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit idle, can accept a request |
| req_lin | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| dir_base_wr | input | 1 | Load directory base and invalidate cache |
| dir_base_in | input | 20 | Directory base frame number |
| flush | input | 1 | Invalidate all cache entries |
| mem_req_valid | output | 1 | Table read request, one cycle |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table entry returned |

## Verification
On every cycle the assertions check the following:
- The table read request and the result strobe each last a single cycle.
- `req_ready` drops after each acceptance.
- A faulting result carries a zero address.
- A flush leaves no valid entry.
- Each refill marks the slot it wrote as valid.

Only the bench scenarios can show the rest, because it depends on table contents and on history:
- The translated values and the latencies of hits, 4 MB walks and 4 KB walks.
- That faults leave the cache untouched.
- That a 4 MB entry hits across its whole span.
- The round-robin eviction order.
- That a base write takes effect.

// File: rtl/pgx_pkg.sv
`timescale 1ns/1ps
package pgx_pkg;
    localparam int LIN_W    = 32;
    localparam int OFF_W    = 12;                 // 4 KB page offset
    localparam int IDX_W    = 10;                 // bits per table index
    localparam int VPN_W    = LIN_W - OFF_W;      // 4 KB virtual page number
    localparam int BIG_OFF_W = OFF_W + IDX_W;     // 4 MB page offset
    localparam int BIG_VPN_W = LIN_W - BIG_OFF_W; // directory index
    localparam int PRESENT_BIT = 0;
    localparam int LARGE_BIT   = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_PT_REQ,
        S_PT_WAIT,
        S_DONE
    } walk_state_e;
endpackage

// File: rtl/pgx_xlat_cache.sv
`timescale 1ns/1ps
module pgx_xlat_cache
    import pgx_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval_all,
    input  logic [LIN_W-1:0] look_lin,
    output logic             hit,
    output logic [LIN_W-1:0] hit_phys,
    input  logic             fill_en,
    input  logic [LIN_W-1:0] fill_lin,
    input  logic [VPN_W-1:0] fill_frame,
    input  logic             fill_big
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] big_q;
    logic [VPN_W-1:0]   tag_q   [ENTRIES];
    logic [VPN_W-1:0]   frame_q [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] match;

    // per-slot comparators; a large page compares only its directory index
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] &&
            (big_q[g] ? (tag_q[g][VPN_W-1 -: BIG_VPN_W] == look_lin[LIN_W-1 -: BIG_VPN_W])
                      : (tag_q[g] == look_lin[LIN_W-1 -: VPN_W]));
    end

    always_comb begin
        hit      = 1'b0;
        hit_phys = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i] && !hit) begin
                hit      = 1'b1;
                hit_phys = big_q[i]
                    ? {frame_q[i][VPN_W-1 -: BIG_VPN_W], look_lin[BIG_OFF_W-1:0]}
                    : {frame_q[i], look_lin[OFF_W-1:0]};
            end
        end
    end

    // control state: valid bits and replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (inval_all) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (fill_en && !inval_all) begin
            tag_q[ptr_q]   <= fill_lin[LIN_W-1 -: VPN_W];
            frame_q[ptr_q] <= fill_frame;
            big_q[ptr_q]   <= fill_big;
        end
    end

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (valid_q == '0));

    p_fill_marks_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inval_all) |=> valid_q[$past(ptr_q)]);
endmodule

// File: rtl/pgx_walker.sv
`timescale 1ns/1ps
module pgx_walker
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LIN_W-1:0] req_lin,
    input  logic [VPN_W-1:0] dir_frame,
    output logic [LIN_W-1:0] look_lin,
    input  logic             cache_hit,
    input  logic [LIN_W-1:0] cache_phys,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_frame,
    output logic             fill_big,
    output logic             mem_req_valid,
    output logic [LIN_W-1:0] mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [LIN_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [LIN_W-1:0] rsp_phys,
    output logic             rsp_fault
);
    walk_state_e state_q, state_d;
    logic [LIN_W-1:0] lin_q, pde_q, res_phys_q;
    logic             res_fault_q;
    logic             ent_present, ent_large;

    assign ent_present = mem_rsp_data[PRESENT_BIT];
    assign ent_large   = mem_rsp_data[LARGE_BIT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_PROBE;
            S_PROBE:    state_d = cache_hit ? S_DONE : S_DIR_REQ;
            S_DIR_REQ:  state_d = S_DIR_WAIT;
            S_DIR_WAIT: if (mem_rsp_valid)
                            state_d = (!ent_present || ent_large) ? S_DONE : S_PT_REQ;
            S_PT_REQ:   state_d = S_PT_WAIT;
            S_PT_WAIT:  if (mem_rsp_valid) state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q       <= '0;
            pde_q       <= '0;
            res_phys_q  <= '0;
            res_fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) lin_q <= req_lin;
                S_PROBE: if (cache_hit) begin
                    res_phys_q  <= cache_phys;
                    res_fault_q <= 1'b0;
                end
                S_DIR_WAIT: if (mem_rsp_valid) begin
                    pde_q <= mem_rsp_data;
                    if (!ent_present) begin
                        res_phys_q  <= '0;
                        res_fault_q <= 1'b1;
                    end else if (ent_large) begin
                        res_phys_q  <= {mem_rsp_data[LIN_W-1 -: BIG_VPN_W], lin_q[BIG_OFF_W-1:0]};
                        res_fault_q <= 1'b0;
                    end
                end
                S_PT_WAIT: if (mem_rsp_valid) begin
                    res_phys_q  <= ent_present ? {mem_rsp_data[LIN_W-1 -: VPN_W], lin_q[OFF_W-1:0]} : '0;
                    res_fault_q <= !ent_present;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        fill_en       = 1'b0;
        fill_big      = 1'b0;
        unique case (state_q)
            S_IDLE:     req_ready = 1'b1;
            S_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {dir_frame, lin_q[LIN_W-1 -: BIG_VPN_W], 2'b00};
            end
            S_DIR_WAIT: begin
                fill_en  = mem_rsp_valid && ent_present && ent_large;
                fill_big = 1'b1;
            end
            S_PT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {pde_q[LIN_W-1 -: VPN_W], lin_q[BIG_OFF_W-1:OFF_W], 2'b00};
            end
            S_PT_WAIT:  fill_en = mem_rsp_valid && ent_present;
            S_DONE:     rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign fill_frame = mem_rsp_data[LIN_W-1 -: VPN_W];
    assign look_lin   = lin_q;
    assign rsp_phys   = res_phys_q;
    assign rsp_fault  = res_fault_q;

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_memreq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    p_fault_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_phys == '0));
endmodule

// File: rtl/pgx_xlate_top.sv
`timescale 1ns/1ps
module pgx_xlate_top
    import pgx_pkg::*;
#(
    parameter int CACHE_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin,
    output logic        rsp_valid,
    output logic [31:0] rsp_phys,
    output logic        rsp_fault,
    input  logic        dir_base_wr,
    input  logic [19:0] dir_base_in,
    input  logic        flush,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    logic [VPN_W-1:0] dir_base_q;
    logic [LIN_W-1:0] look_lin, cache_phys;
    logic             cache_hit, fill_en, fill_big;
    logic [VPN_W-1:0] fill_frame;

    always_ff @(posedge clk) begin
        if (!rst_n)           dir_base_q <= '0;
        else if (dir_base_wr) dir_base_q <= dir_base_in;
    end

    pgx_xlat_cache #(.ENTRIES(CACHE_ENTRIES)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval_all  (flush | dir_base_wr),
        .look_lin   (look_lin),
        .hit        (cache_hit),
        .hit_phys   (cache_phys),
        .fill_en    (fill_en),
        .fill_lin   (look_lin),
        .fill_frame (fill_frame),
        .fill_big   (fill_big)
    );

    pgx_walker u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_lin       (req_lin),
        .dir_frame     (dir_base_q),
        .look_lin      (look_lin),
        .cache_hit     (cache_hit),
        .cache_phys    (cache_phys),
        .fill_en       (fill_en),
        .fill_frame    (fill_frame),
        .fill_big      (fill_big),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_phys      (rsp_phys),
        .rsp_fault     (rsp_fault)
    );

    p_base_write_stalls_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_base_wr && !fill_en) |=> !(cache_hit && $past(cache_hit)) || !$stable(look_lin));
endmodule

// File: tb/pgx_xlate_top_bench.sv
`timescale 1ns/1ps
module pgx_xlate_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_ready, rsp_valid, rsp_fault;
    logic [31:0] rsp_phys;
    logic        dir_base_wr = 1'b0;
    logic [19:0] dir_base_in = '0;
    logic        flush = 1'b0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] mem [logic [31:0]];

    always #4 clk = ~clk;   // 125 MHz

    pgx_xlate_top u_pgx_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
        .dir_base_wr(dir_base_wr), .dir_base_in(dir_base_in), .flush(flush),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // one-cycle table memory; unknown words read as zero (not present)
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= mem_req_valid;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] lin, input logic [31:0] ephys,
                         input bit efault, input int elat, input string req);
        int lat = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_lin   = lin;
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            #1 lat++;
            if (rsp_valid) break;
        end
        chk(rsp_valid == 1'b1, {req, " result strobe"}, 32'(rsp_valid), 32'd1);
        chk(rsp_fault == efault, {req, " fault"}, 32'(rsp_fault), 32'(efault));
        chk(rsp_phys == ephys, {req, " phys"}, rsp_phys, ephys);
        chk(lat == elat, {req, " latency"}, 32'(lat), 32'(elat));
        chk(req_ready == 1'b0, "R2 busy while result shown", 32'(req_ready), 32'd0);
        @(posedge clk);
        #1 chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R2 strobe one cycle, ready again",
               {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic load_base(input logic [19:0] b);
        @(negedge clk);
        dir_base_wr = 1'b1;
        dir_base_in = b;
        @(negedge clk);
        dir_base_wr = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] lin;
        logic [31:0] phys;
        logic        fault;
        logic [3:0]  lat;
    } vec_t;

    // R3 hit: 1, R5 large page walk: 3, R6 small page walk: 5
    localparam vec_t VEC [10] = '{
        '{32'h00405ABC, 32'h12345ABC, 1'b0, 4'd5},  // R6 miss, small page
        '{32'h00405123, 32'h12345123, 1'b0, 4'd1},  // R3 hit same page
        '{32'h00812345, 32'h0C012345, 1'b0, 4'd3},  // R5 large page walk
        '{32'h00BFFFFF, 32'h0C3FFFFF, 1'b0, 4'd1},  // R8 large entry hits far offset
        '{32'h00C00010, 32'h00000000, 1'b1, 4'd3},  // R7 directory not present
        '{32'h00C00010, 32'h00000000, 1'b1, 4'd3},  // R7 no fill, walks again
        '{32'h00406000, 32'h00000000, 1'b1, 4'd5},  // R7 table entry not present
        '{32'h00407FFF, 32'h0ABCDFFF, 1'b0, 4'd5},  // R8 small entry: neighbour page misses
        '{32'h00406000, 32'h00000000, 1'b1, 4'd5},  // R7 still walks
        '{32'h00405000, 32'h12345000, 1'b0, 4'd1}   // R8 small page still hits
    };

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // tables: directory at 0x00010000, page table at 0x00020000
        mem[32'h00010004] = 32'h00020001;   // idx 1 -> page table
        mem[32'h00010008] = 32'h0C000081;   // idx 2 -> 4 MB page
        mem[32'h00020014] = 32'h12345001;   // pte 5
        mem[32'h0002001C] = 32'h0ABCD001;   // pte 7
        for (int i = 0; i <= 32; i++)
            mem[32'h00030000 + 32'(i * 4)] = (32'(i + 16) << 22) | 32'h81;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 no result after reset", 32'(rsp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R1 no read after reset", 32'(mem_req_valid), 32'd0);

        load_base(20'h00010);   // R4 directory base
        for (int v = 0; v < 10; v++)
            xlate(VEC[v].lin, VEC[v].phys, VEC[v].fault, int'(VEC[v].lat), "R4/R6 vector");

        // R10 flush
        xlate(32'h00405ABC, 32'h12345ABC, 1'b0, 1, "R3 hit before flush");
        pulse_flush();
        xlate(32'h00405ABC, 32'h12345ABC, 1'b0, 5, "R10 miss after flush");
        xlate(32'h00812345, 32'h0C012345, 1'b0, 3, "R10 large entry gone");

        // R11 base write invalidates and redirects walks
        load_base(20'h00030);
        xlate(32'h00405ABC, 32'h04405ABC, 1'b0, 3, "R11 new directory used");

        // R9 round robin: idx1 filled first, then 0,2..32 (33 fills total)
        for (int i = 0; i <= 32; i++) begin
            if (i != 1)
                xlate(32'(i) << 22 | 32'h123, (32'(i + 16) << 22) | 32'h123, 1'b0, 3, "R9 fill");
        end
        xlate(32'h00000777, 32'h04000777, 1'b0, 1, "R9 idx0 survives");
        xlate(32'h00400777, 32'h04400777, 1'b0, 3, "R9 oldest evicted");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule